// File: doc/BRIEF.md
# Four-Stage Pipeline Hazard Controller

This block steers an in-order pipeline with four steps (fetch, decode with operand read, execute, write-back) and three buffers between them. The decode buffer holds the instruction being decoded, the execute buffer the one in the ALU, and the write buffer the one retiring. Every cycle it looks at the fetch port, the execute-busy flag and the register numbers held in the buffers. From these it decides which buffers hold, where bubbles go in, which operands bypass the register file, and whether a younger fetch is thrown away.

A small register-tag file sits inside so the control can be tested end to end. Each instruction carries a unique tag, and the write stage writes that tag into its destination register. The two operand values captured for execute are tags taken from the register file, the execute buffer or the write buffer. A checker can therefore see at retirement which producer each operand came from. A mode input chooses between bypassing (no dependency stall) and a plain interlock that waits until the producer has written back.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: After reset all three buffers are empty: `wb_valid_o`, `squash_o`, both hold outputs and both bubble outputs are 0, and `if_ready_o` is 1.
- R2: With no hazard, an instruction accepted at a clock edge (`if_valid_i` and `if_ready_o` both 1) is in decode for the next cycle and in execute for the cycle after. It appears on the `wb_*` outputs in the third cycle after acceptance, and one instruction is accepted per cycle.
- R3: While execute holds a valid instruction and `ex_busy_i` is 1, the decode and execute buffers keep their contents (`hold_dec_o`=1, `hold_exe_o`=1, `if_ready_o`=0), and the write buffer receives a bubble (`bubble_wb_o`=1). `ex_busy_i` has no effect while execute is empty.
- R4: A cycle with `if_valid_i`=0 and `if_ready_o`=1 puts an empty slot into decode. That slot moves down the pipe and leaves `wb_valid_o`=0 three cycles after the edge.
- R5: With `fwd_en_i`=1, a source register equal to the destination of the valid execute-stage instruction selects code 1 (execute result). Otherwise, a match with the valid write-stage instruction selects code 2. Otherwise code 0 (register file) applies. The execute match wins when both match, and no dependency stall occurs.
- R6: With `fwd_en_i`=0, both selects stay 0. A decode instruction whose source matches the destination of a valid execute- or write-stage instruction is held, with `hold_dec_o`=1 and a bubble into execute (`bubble_exe_o`=1). A back-to-back dependency is held exactly two cycles.
- R7: Register 0 never creates a dependency: a source of 0 always selects code 0, reads tag 0, and never stalls.
- R8: A taken branch in decode asserts `squash_o` in the cycle it moves on to execute. The instruction fetched in that same cycle is discarded and never reaches write-back. Exactly one fetch slot is lost.
- R9: A stall in execute takes priority over a squash. While execute is stalled, `squash_o` stays 0 and the branch stays in decode; the squash happens in the cycle the branch actually leaves decode.
- R10: The operand tags shown with each retiring instruction (`wb_opa_o`, `wb_opb_o`) equal the tag of the most recent older instruction on the taken path that wrote that register, or 0 if there is none. This holds in both modes.
- R11: Empty and squashed slots never write the register-tag file: a register whose only writer was squashed still reads its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwd_en_i | input | 1 | 1: bypass from execute/write buffers; 0: interlock |
| if_valid_i | input | 1 | Fetch delivers an instruction this cycle (0 = miss pending) |
| if_tag_i | input | TAG_W | Unique tag of the fetched instruction |
| if_src_a_i | input | RW | First source register |
| if_src_b_i | input | RW | Second source register |
| if_dst_i | input | RW | Destination register (0 = none) |
| if_taken_i | input | 1 | Instruction is a branch that resolves taken in decode |
| ex_busy_i | input | 1 | Execute needs another cycle for its instruction |
| if_ready_o | output | 1 | Fetched instruction is accepted at the next edge |
| hold_dec_o | output | 1 | Decode buffer keeps its contents |
| hold_exe_o | output | 1 | Execute buffer keeps its contents |
| bubble_exe_o | output | 1 | Empty slot inserted into execute (dependency interlock) |
| bubble_wb_o | output | 1 | Empty slot inserted into write (execute busy) |
| fwd_sel_a_o | output | 2 | Operand A source: 0 file, 1 execute, 2 write |
| fwd_sel_b_o | output | 2 | Operand B source: 0 file, 1 execute, 2 write |
| squash_o | output | 1 | Taken branch leaves decode; current fetch discarded |
| wb_valid_o | output | 1 | Write stage holds a real instruction |
| wb_tag_o | output | TAG_W | Tag of the retiring instruction |
| wb_dst_o | output | RW | Destination of the retiring instruction |
| wb_opa_o | output | TAG_W | Operand A tag captured for that instruction |
| wb_opb_o | output | TAG_W | Operand B tag captured for that instruction |

## Verification
The checker watches the local relations on every cycle. A busy execute freezes its buffer and starves write-back. A squash leaves decode empty. Register 0 and interlock mode never select a bypass. A stall blocks a squash. Bypass mode with an idle execute never refuses a fetch, and a fetch miss lands as an empty decode slot. Exact stall lengths, the one-slot branch penalty, and whether every operand tag matches the program-order producer (including after a squashed writer) can only be shown by the bench's scenarios. These run a short branchy program with misses and multi-cycle executes, once in each mode, against its cycle model and an architectural register model.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF = 2'd0,
    SEL_EX = 2'd1,
    SEL_WB = 2'd2
  } opnd_sel_e;
endpackage

// File: rtl/hz_stage_buf.sv
module hz_stage_buf #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  output logic         vld_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else if (!hold_i) begin
      vld_o  <= vld_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/hz_tag_rf.sv
module hz_tag_rf #(
  parameter int NREG  = 16,
  parameter int TAG_W = 8,
  parameter int NRD   = 2,
  localparam int RW   = $clog2(NREG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [RW-1:0]             waddr_i,
  input  logic [TAG_W-1:0]          wdata_i,
  input  logic [NRD-1:0][RW-1:0]    raddr_i,
  output logic [NRD-1:0][TAG_W-1:0] rdata_o
);
  logic [NREG-1:0][TAG_W-1:0] mem_q;

  // entry 0 is never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rdata_o[k] = (raddr_i[k] == '0) ? '0 : mem_q[raddr_i[k]];
  end
endmodule

// File: rtl/hz_detect.sv
module hz_detect
  import pipe_hz_pkg::*;
#(
  parameter int RW   = 4,
  parameter int NSRC = 2
) (
  input  logic                     fwd_en_i,
  input  logic                     ex_busy_i,
  input  logic                     d_vld_i,
  input  logic [NSRC-1:0][RW-1:0]  d_src_i,
  input  logic                     e_vld_i,
  input  logic [RW-1:0]            e_dst_i,
  input  logic                     w_vld_i,
  input  logic [RW-1:0]            w_dst_i,
  output logic                     ex_stall_o,
  output logic                     raw_stall_o,
  output logic [NSRC-1:0][1:0]     sel_o
);
  logic [NSRC-1:0] dep_e, dep_w;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic      live;
    opnd_sel_e sel;
    assign live     = d_vld_i && (d_src_i[k] != '0);
    assign dep_e[k] = live && e_vld_i && (e_dst_i == d_src_i[k]);
    assign dep_w[k] = live && w_vld_i && (w_dst_i == d_src_i[k]);
    always_comb begin
      sel = SEL_RF;
      if (fwd_en_i) begin
        if (dep_e[k])      sel = SEL_EX;  // youngest producer first
        else if (dep_w[k]) sel = SEL_WB;
      end
    end
    assign sel_o[k] = sel;
  end

  assign ex_stall_o  = e_vld_i && ex_busy_i;
  assign raw_stall_o = !fwd_en_i && ((|dep_e) || (|dep_w));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hz_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int TAG_W = 8,
  localparam int RW   = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fwd_en_i,
  input  logic             if_valid_i,
  input  logic [TAG_W-1:0] if_tag_i,
  input  logic [RW-1:0]    if_src_a_i,
  input  logic [RW-1:0]    if_src_b_i,
  input  logic [RW-1:0]    if_dst_i,
  input  logic             if_taken_i,
  input  logic             ex_busy_i,
  output logic             if_ready_o,
  output logic             hold_dec_o,
  output logic             hold_exe_o,
  output logic             bubble_exe_o,
  output logic             bubble_wb_o,
  output logic [1:0]       fwd_sel_a_o,
  output logic [1:0]       fwd_sel_b_o,
  output logic             squash_o,
  output logic             wb_valid_o,
  output logic [TAG_W-1:0] wb_tag_o,
  output logic [RW-1:0]    wb_dst_o,
  output logic [TAG_W-1:0] wb_opa_o,
  output logic [TAG_W-1:0] wb_opb_o
);
  localparam int NSRC = 2;

  typedef struct packed {
    logic             tk;
    logic [RW-1:0]    dst;
    logic [RW-1:0]    sb;
    logic [RW-1:0]    sa;
    logic [TAG_W-1:0] tag;
  } dslot_t;

  typedef struct packed {
    logic [RW-1:0]    dst;
    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] opa;
    logic [TAG_W-1:0] opb;
  } eslot_t;

  logic   d_vld, e_vld, w_vld;
  dslot_t d_q, d_in;
  eslot_t e_q, e_in, w_q;

  logic ex_stall, raw_stall, hold_dec, squash;
  logic [NSRC-1:0][RW-1:0]    src;
  logic [NSRC-1:0][1:0]       sel;
  logic [NSRC-1:0][TAG_W-1:0] rf_rd, opnd;

  assign src[0] = d_q.sa;
  assign src[1] = d_q.sb;

  hz_detect #(.RW(RW), .NSRC(NSRC)) u_det (
    .fwd_en_i   (fwd_en_i),
    .ex_busy_i  (ex_busy_i),
    .d_vld_i    (d_vld),
    .d_src_i    (src),
    .e_vld_i    (e_vld),
    .e_dst_i    (e_q.dst),
    .w_vld_i    (w_vld),
    .w_dst_i    (w_q.dst),
    .ex_stall_o (ex_stall),
    .raw_stall_o(raw_stall),
    .sel_o      (sel)
  );

  hz_tag_rf #(.NREG(NREG), .TAG_W(TAG_W), .NRD(NSRC)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (w_vld),
    .waddr_i(w_q.dst),
    .wdata_i(w_q.tag),
    .raddr_i(src),
    .rdata_o(rf_rd)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_opnd
    always_comb begin
      unique case (sel[k])
        SEL_EX:  opnd[k] = e_q.tag;
        SEL_WB:  opnd[k] = w_q.tag;
        default: opnd[k] = rf_rd[k];
      endcase
    end
  end

  assign hold_dec = ex_stall || raw_stall;
  // branch resolved in decode; only squashes once it really moves on
  assign squash   = d_vld && d_q.tk && !hold_dec;

  assign d_in = '{tk: if_taken_i, dst: if_dst_i, sb: if_src_b_i,
                  sa: if_src_a_i, tag: if_tag_i};
  assign e_in = '{dst: d_q.dst, tag: d_q.tag, opa: opnd[0], opb: opnd[1]};

  hz_stage_buf #(.W($bits(dslot_t))) u_buf_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold_dec),
    .vld_i (if_valid_i && !squash),
    .data_i(d_in),
    .vld_o (d_vld),
    .data_o(d_q)
  );

  hz_stage_buf #(.W($bits(eslot_t))) u_buf_exe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(ex_stall),
    .vld_i (d_vld && !raw_stall),
    .data_i(e_in),
    .vld_o (e_vld),
    .data_o(e_q)
  );

  hz_stage_buf #(.W($bits(eslot_t))) u_buf_wb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(1'b0),
    .vld_i (e_vld && !ex_stall),
    .data_i(e_q),
    .vld_o (w_vld),
    .data_o(w_q)
  );

  assign if_ready_o   = !hold_dec;
  assign hold_dec_o   = hold_dec;
  assign hold_exe_o   = ex_stall;
  assign bubble_exe_o = raw_stall && !ex_stall;
  assign bubble_wb_o  = ex_stall;
  assign fwd_sel_a_o  = sel[0];
  assign fwd_sel_b_o  = sel[1];
  assign squash_o     = squash;
  assign wb_valid_o   = w_vld;
  assign wb_tag_o     = w_q.tag;
  assign wb_dst_o     = w_q.dst;
  assign wb_opa_o     = w_q.opa;
  assign wb_opb_o     = w_q.opb;
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int RW    = 4,
  parameter int TAG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fwd_en_i,
  input logic             if_valid_i,
  input logic             ex_busy_i,
  input logic             if_ready_o,
  input logic             hold_exe_o,
  input logic             squash_o,
  input logic             wb_valid_o,
  input logic [1:0]       fwd_sel_a_o,
  input logic [1:0]       fwd_sel_b_o,
  input logic             d_vld,
  input logic [RW-1:0]    d_sa,
  input logic [RW-1:0]    d_sb,
  input logic             e_vld,
  input logic [TAG_W-1:0] e_tag
);
  assert_busy_starves_wb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_vld && ex_busy_i) |=> !wb_valid_o);

  assert_busy_freezes_exe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_exe_o |=> (e_vld && $stable(e_tag)));

  assert_miss_empties_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!if_valid_i && if_ready_o) |=> !d_vld);

  assert_fwd_no_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_en_i && !ex_busy_i) |-> if_ready_o);

  assert_interlock_no_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_en_i |-> (fwd_sel_a_o == 2'd0 && fwd_sel_b_o == 2'd0));

  assert_reg0_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_sa == '0) |-> (fwd_sel_a_o == 2'd0));

  assert_reg0_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_sb == '0) |-> (fwd_sel_b_o == 2'd0));

  assert_squash_empties_dec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |=> !d_vld);

  assert_stall_beats_squash_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_exe_o |-> !squash_o);
endmodule

bind pipe_hazard_ctrl hz_checker #(.RW(RW), .TAG_W(TAG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fwd_en_i   (fwd_en_i),
  .if_valid_i (if_valid_i),
  .ex_busy_i  (ex_busy_i),
  .if_ready_o (if_ready_o),
  .hold_exe_o (hold_exe_o),
  .squash_o   (squash_o),
  .wb_valid_o (wb_valid_o),
  .fwd_sel_a_o(fwd_sel_a_o),
  .fwd_sel_b_o(fwd_sel_b_o),
  .d_vld      (d_vld),
  .d_sa       (d_q.sa),
  .d_sb       (d_q.sb),
  .e_vld      (e_vld),
  .e_tag      (e_q.tag)
);

// File: tb/sim_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_pipe_hazard_ctrl;
  localparam int NREG  = 16;
  localparam int TAG_W = 8;
  localparam int RW    = 4;
  localparam int PLEN  = 14;
  localparam int NPATH = 11;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fwd_en_i = 1'b0, if_valid_i = 1'b0, if_taken_i = 1'b0, ex_busy_i = 1'b0;
  logic [TAG_W-1:0] if_tag_i = '0;
  logic [RW-1:0] if_src_a_i = '0, if_src_b_i = '0, if_dst_i = '0;
  logic if_ready_o, hold_dec_o, hold_exe_o, bubble_exe_o, bubble_wb_o, squash_o, wb_valid_o;
  logic [1:0] fwd_sel_a_o, fwd_sel_b_o;
  logic [TAG_W-1:0] wb_tag_o, wb_opa_o, wb_opb_o;
  logic [RW-1:0] wb_dst_o;

  always #2 clk_i = ~clk_i;

  pipe_hazard_ctrl #(.NREG(NREG), .TAG_W(TAG_W)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // program: sources, destination, taken, target, extra execute cycles, miss cycles
  int p_sa[PLEN], p_sb[PLEN], p_dst[PLEN], p_tk[PLEN], p_tgt[PLEN], p_ex[PLEN], p_ms[PLEN];

  task automatic put(int i, int sa, int sb, int dst, int tk, int tgt, int ex, int ms);
    p_sa[i] = sa; p_sb[i] = sb; p_dst[i] = dst; p_tk[i] = tk;
    p_tgt[i] = tgt; p_ex[i] = ex; p_ms[i] = ms;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle model state
  int dV, dT, dSa, dSb, dDst, dTk;
  int eV, eT, eDst, eOa, eOb;
  int wV, wT, wDst, wOa, wOb;
  int mrf[NREG];
  int arf[NREG];
  int pc, miss_left, busy_left, arch_pc, retired, cyc;

  task automatic run_phase(int fwd);
    int exs, raw, hd, sq, ifv, sela, selb, oa, ob;
    int dea, deb, dwa, dwb;
    dV = 0; eV = 0; wV = 0; dT = 0; eT = 0; wT = 0;
    dSa = 0; dSb = 0; dDst = 0; dTk = 0; eDst = 0; wDst = 0;
    eOa = 0; eOb = 0; wOa = 0; wOb = 0;
    for (int r = 0; r < NREG; r++) begin mrf[r] = 0; arf[r] = 0; end
    pc = 0; miss_left = p_ms[0]; busy_left = 0; arch_pc = 0; retired = 0; cyc = 0;
    @(negedge clk_i);
    rst_ni = 1'b0; if_valid_i = 1'b0; ex_busy_i = 1'b0; fwd_en_i = fwd[0];
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 wb_valid", int'(wb_valid_o), 0);
    chk("R1 if_ready", int'(if_ready_o), 1);
    chk("R1 hold_dec", int'(hold_dec_o), 0);
    chk("R1 hold_exe", int'(hold_exe_o), 0);
    chk("R1 bubble_exe", int'(bubble_exe_o), 0);
    chk("R1 bubble_wb", int'(bubble_wb_o), 0);
    chk("R1 squash", int'(squash_o), 0);
    while (!(pc >= PLEN && dV == 0 && eV == 0 && wV == 0) && cyc < 300) begin
      @(negedge clk_i);
      cyc++;
      ifv = (pc < PLEN && miss_left == 0) ? 1 : 0;
      fwd_en_i   = fwd[0];
      if_valid_i = ifv[0];
      if_tag_i   = TAG_W'(pc + 1);
      if_src_a_i = (pc < PLEN) ? RW'(p_sa[pc]) : '0;
      if_src_b_i = (pc < PLEN) ? RW'(p_sb[pc]) : '0;
      if_dst_i   = (pc < PLEN) ? RW'(p_dst[pc]) : '0;
      if_taken_i = (pc < PLEN) ? p_tk[pc][0] : 1'b0;
      // busy noise while execute is empty must have no effect (R3)
      ex_busy_i  = (eV != 0) ? (busy_left > 0) : (cyc % 3 == 0);
      #1;
      exs = (eV != 0 && ex_busy_i) ? 1 : 0;
      dea = (dV != 0 && dSa != 0 && eV != 0 && eDst == dSa) ? 1 : 0;
      deb = (dV != 0 && dSb != 0 && eV != 0 && eDst == dSb) ? 1 : 0;
      dwa = (dV != 0 && dSa != 0 && wV != 0 && wDst == dSa) ? 1 : 0;
      dwb = (dV != 0 && dSb != 0 && wV != 0 && wDst == dSb) ? 1 : 0;
      raw = (fwd == 0 && (dea + deb + dwa + dwb) > 0) ? 1 : 0;
      hd  = (exs != 0 || raw != 0) ? 1 : 0;
      sq  = (dV != 0 && dTk != 0 && hd == 0) ? 1 : 0;
      sela = (fwd == 0) ? 0 : (dea != 0) ? 1 : (dwa != 0) ? 2 : 0;
      selb = (fwd == 0) ? 0 : (deb != 0) ? 1 : (dwb != 0) ? 2 : 0;
      oa = (sela == 1) ? eT : (sela == 2) ? wT : mrf[dSa];
      ob = (selb == 1) ? eT : (selb == 2) ? wT : mrf[dSb];

      chk("R3 if_ready", int'(if_ready_o), 1 - hd);
      chk("R3 hold_exe", int'(hold_exe_o), exs);
      chk("R3 bubble_wb", int'(bubble_wb_o), exs);
      chk("R6 hold_dec", int'(hold_dec_o), hd);
      chk("R6 bubble_exe", int'(bubble_exe_o), (raw != 0 && exs == 0) ? 1 : 0);
      chk((dV != 0 && dTk != 0 && exs != 0) ? "R9 squash" : "R8 squash", int'(squash_o), sq);
      chk((dSa == 0) ? "R7 sel_a" : "R5 sel_a", int'(fwd_sel_a_o), sela);
      chk((dSb == 0) ? "R7 sel_b" : "R5 sel_b", int'(fwd_sel_b_o), selb);
      chk("R4 wb_valid", int'(wb_valid_o), wV);
      if (wV != 0) begin
        chk("R2 wb_tag", int'(wb_tag_o), wT);
        chk("R2 wb_dst", int'(wb_dst_o), wDst);
        // architectural path and register model, independent of timing
        chk("R8 path", int'(wb_tag_o), arch_pc + 1);
        chk((wT == 9) ? "R11 opa" : "R10 opa", int'(wb_opa_o), arf[p_sa[wT-1]]);
        chk("R10 opb", int'(wb_opb_o), arf[p_sb[wT-1]]);
        if (p_dst[wT-1] != 0) arf[p_dst[wT-1]] = wT;
        arch_pc = (p_tk[wT-1] != 0) ? p_tgt[wT-1] : arch_pc + 1;
        retired++;
      end

      // model state at the coming edge
      if (wV != 0 && wDst != 0) mrf[wDst] = wT;
      if (exs == 0) begin
        wV = eV; wT = eT; wDst = eDst; wOa = eOa; wOb = eOb;
      end else begin
        wV = 0;
      end
      if (exs == 0) begin
        if (raw != 0) begin
          eV = 0; busy_left = 0;
        end else begin
          eV = dV; eT = dT; eDst = dDst; eOa = oa; eOb = ob;
          busy_left = (dV != 0) ? p_ex[dT-1] : 0;
        end
      end else begin
        busy_left--;
      end
      if (sq != 0) begin
        pc = p_tgt[dT-1];
        miss_left = p_ms[pc];
      end else if (hd == 0 && ifv != 0) begin
        pc++;
        miss_left = (pc < PLEN) ? p_ms[pc] : 0;
      end else if (miss_left > 0) begin
        miss_left--;
      end
      if (hd == 0) begin
        dV = (ifv != 0 && sq == 0) ? 1 : 0;
        dT = int'(if_tag_i); dSa = int'(if_src_a_i); dSb = int'(if_src_b_i);
        dDst = int'(if_dst_i); dTk = int'(if_taken_i);
      end
    end
    chk("R8 retired count", retired, NPATH);
    chk("R8 final path", arch_pc, PLEN);
  endtask

  initial begin
    // idx  sa sb dst tk tgt ex ms
    put(0,  0, 0, 1, 0, 0,  0, 0);
    put(1,  1, 0, 2, 0, 0,  0, 0);   // depends on execute stage
    put(2,  1, 2, 3, 0, 0,  0, 0);   // a from write stage, b from execute
    put(3,  3, 0, 0, 0, 0,  0, 2);   // miss before fetch, writes nothing
    put(4,  0, 0, 4, 0, 0,  2, 0);   // register 0 sources, slow execute
    put(5,  4, 0, 0, 1, 8,  0, 0);   // taken branch during execute stall
    put(6,  0, 0, 5, 0, 0,  0, 0);   // shadow slot, squashed
    put(7,  0, 0, 6, 0, 0,  0, 0);   // skipped
    put(8,  5, 3, 7, 0, 0,  0, 1);   // r5 must read 0
    put(9,  7, 7, 5, 0, 0,  1, 0);
    put(10, 5, 7, 1, 0, 0,  0, 0);
    put(11, 1, 0, 0, 1, 13, 0, 0);   // taken branch with dependency
    put(12, 0, 0, 2, 0, 0,  0, 0);   // shadow slot, squashed
    put(13, 2, 1, 3, 0, 0,  0, 0);
    run_phase(1);
    run_phase(0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog: actual=running expected=drained");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule